// File: doc/BRIEF.md
# Eye Mask Error-Rate Sweep Sequencer

This block runs a measurement campaign over a family of rectangular eye masks and produces a two-dimensional error map of a received serial signal. An external mask controller holds three positions: a vertical level, an early sampling phase and a late sampling phase. The sequencer moves that controller through every mask with one-cycle step and clear pulses. The front end gives one error pulse per bit-clock cycle whenever a data transition falls inside the current mask. For each mask the sequencer watches a window of bit-clock cycles, counts the error pulses and emits a result record. The record carries the mask coordinates, the raw count, a fixed-point mask error rate and a pass flag against a programmed rate threshold.

The early and the late edges are moved separately, so an eye that is not symmetric still maps correctly. For each vertical level the early edge is swept first with the late edge at its origin. The late edge is then swept with the early edge at its origin. The rate estimate takes half the bits in the window as the number of transitions, and scales each counted pulse by a prescale ratio. While the sweep runs, the sequencer tracks the largest mask whose rate stays at or below the threshold. All masks that share the same rate, read from the map, give the effective two-dimensional opening.

The result stream uses valid/ready. A record stays on the outputs, unchanged, until it is accepted. While a record waits, the sweep pauses and no window runs, so back-pressure costs time but never loses or reorders a record. The start, configuration, control pulses and status pins are plain level or pulse signals.

Top module: `mer_sweep_seq`

## Requirements
- R1: After a start, records come out in this order. For each vertical index v from 0 to NUM_V-1: early index e from 0 to NUM_P-1 with late index 0, then late index l from 0 to NUM_P-1 with early index 0. That gives 2*NUM_V*NUM_P records, and the first is (0,0,0).
- R2: Each mask is observed for exactly 2^w bit-clock cycles, and res_count equals the number of those cycles with err_pulse high. w is cfg_win_log2 sampled at start, with 0 read as 1 and values above MAX_WIN_LOG2 read as MAX_WIN_LOG2.
- R3: res_rate = floor(res_count * PRESCALE * 2^(RATE_FRAC+1) / 2^w), an unsigned fixed-point value with RATE_FRAC fraction bits. res_pass is 1 exactly when res_rate <= the threshold sampled at start.
- R4: While res_valid is high and res_ready is low, the record fields stay unchanged and res_valid stays high. A record is accepted on a clock edge where both are high, and the next window starts only after that.
- R5: Control pulses are one cycle wide, and each appears in the cycle in which mask_v/mask_e/mask_l show the new position. ctl_home comes once per start (all indices to 0). ctl_step_e and ctl_step_l come for each increment of their index. ctl_clr_e comes when the sweep changes from the early to the late edge. ctl_step_v comes together with ctl_clr_l when the vertical level advances. A full sweep therefore gives 1, NUM_V*(NUM_P-1), NUM_V*(NUM_P-1), NUM_V, NUM_V-1 and NUM_V-1 pulses respectively.
- R6: best_v/best_e/best_l hold the passing record with the highest score (v+1)*(e+l+2). On a tie the earlier record wins. best_valid is 0 while no record has passed.
- R7: An accepted start clears done and best_valid and raises busy. After the last record is accepted, busy falls and done rises and holds until the next start.
- R8: A start pulse while busy is ignored. Changes on cfg_thresh or cfg_win_log2 during a sweep have no effect on it.
- R9: After reset, busy, done, res_valid, best_valid and all control pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, taken only when idle |
| cfg_thresh | input | RATE_W | Rate threshold, same fixed-point format as res_rate |
| cfg_win_log2 | input | WL_W | Window length exponent |
| err_pulse | input | 1 | Mask error event for this cycle |
| mask_v | output | V_W | Current vertical level index |
| mask_e | output | P_W | Current early phase index |
| mask_l | output | P_W | Current late phase index |
| ctl_home | output | 1 | Pulse: all mask positions to origin |
| ctl_step_v | output | 1 | Pulse: vertical level up one |
| ctl_step_e | output | 1 | Pulse: early phase out one step |
| ctl_step_l | output | 1 | Pulse: late phase out one step |
| ctl_clr_e | output | 1 | Pulse: early phase back to origin |
| ctl_clr_l | output | 1 | Pulse: late phase back to origin |
| res_valid | output | 1 | Result record valid |
| res_ready | input | 1 | Result record accepted |
| res_v | output | V_W | Record vertical index |
| res_e | output | P_W | Record early index |
| res_l | output | P_W | Record late index |
| res_count | output | CNT_W | Error pulses counted in the window |
| res_rate | output | RATE_W | Mask error rate estimate |
| res_pass | output | 1 | Rate at or below threshold |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep completed |
| best_valid | output | 1 | A passing mask has been found |
| best_v | output | V_W | Best mask vertical index |
| best_e | output | P_W | Best mask early index |
| best_l | output | P_W | Best mask late index |

## Verification
The assertions check the stream's hold rule on every cycle. They also check that only one mask edge is ever away from origin in a record, that indices stay in range and that control pulses never overlap. Other per-cycle checks: a failing record never disturbs the best-mask registers, a zero count always passes, done excludes busy and valid, and a start while busy does not end the sweep or clear the best mask. Only the bench's scenarios can show the complete sweep order, the window length and the counts it yields, the rate arithmetic against the sampled threshold, the clamping of the window exponent, the total pulse counts, and the choice of best mask by score with ties. They use error patterns tied to the mask position, including asymmetric closure on the late side and half-rate toggling.

// File: rtl/mer_pkg.sv
package mer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_MEAS   = 2'd1,
    ST_REPORT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/mer_window_counter.sv
// Observation window timer and error pulse accumulator.
module mer_window_counter #(
  parameter int MAX_WIN_LOG2 = 16,
  parameter int WL_W         = 5,
  parameter int CNT_W        = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic             err,
  input  logic [WL_W-1:0]  win_log2,
  output logic [CNT_W-1:0] err_cnt,
  output logic             win_end
);
  localparam int TMR_W = MAX_WIN_LOG2;

  logic [TMR_W-1:0] timer;
  logic [TMR_W-1:0] win_last;

  assign win_last = (TMR_W'(1) << win_log2) - TMR_W'(1);
  assign win_end  = run && (timer == win_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer   <= '0;
      err_cnt <= '0;
    end else if (clear) begin
      timer   <= '0;
      err_cnt <= '0;
    end else if (run) begin
      timer   <= timer + TMR_W'(1);
      err_cnt <= err_cnt + CNT_W'(err);
    end
  end
endmodule

// File: rtl/mer_rate_calc.sv
// Fixed-point mask error rate: count * prescale over half the window.
module mer_rate_calc #(
  parameter int CNT_W     = 17,
  parameter int WL_W      = 5,
  parameter int PRESCALE  = 1,
  parameter int RATE_FRAC = 8,
  parameter int RATE_W    = 27
) (
  input  logic [CNT_W-1:0]  err_cnt,
  input  logic [WL_W-1:0]   win_log2,
  input  logic [RATE_W-1:0] thresh,
  output logic [RATE_W-1:0] rate,
  output logic              pass
);
  logic [RATE_W-1:0] scaled;
  logic [RATE_W-1:0] lifted;

  assign scaled = RATE_W'(err_cnt) * RATE_W'(PRESCALE);
  // one extra bit of lift divides by half the window instead of the whole
  assign lifted = scaled << (RATE_FRAC + 1);
  assign rate   = lifted >> win_log2;
  assign pass   = (rate <= thresh);
endmodule

// File: rtl/mer_mask_stepper.sv
// Mask position walker: early side, then late side, then next level.
module mer_mask_stepper #(
  parameter int NUM_V = 7,
  parameter int NUM_P = 15,
  parameter int V_W   = 3,
  parameter int P_W   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           home,
  input  logic           advance,
  output logic [V_W-1:0] idx_v,
  output logic [P_W-1:0] idx_e,
  output logic [P_W-1:0] idx_l,
  output logic           last,
  output logic           p_home,
  output logic           p_step_v,
  output logic           p_step_e,
  output logic           p_step_l,
  output logic           p_clr_e,
  output logic           p_clr_l
);
  localparam logic [V_W-1:0] V_TOP = V_W'(NUM_V - 1);
  localparam logic [P_W-1:0] P_TOP = P_W'(NUM_P - 1);

  logic late_side;

  assign last = late_side && (idx_l == P_TOP) && (idx_v == V_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_v     <= '0;
      idx_e     <= '0;
      idx_l     <= '0;
      late_side <= 1'b0;
      p_home    <= 1'b0;
      p_step_v  <= 1'b0;
      p_step_e  <= 1'b0;
      p_step_l  <= 1'b0;
      p_clr_e   <= 1'b0;
      p_clr_l   <= 1'b0;
    end else begin
      p_home   <= 1'b0;
      p_step_v <= 1'b0;
      p_step_e <= 1'b0;
      p_step_l <= 1'b0;
      p_clr_e  <= 1'b0;
      p_clr_l  <= 1'b0;
      if (home) begin
        idx_v     <= '0;
        idx_e     <= '0;
        idx_l     <= '0;
        late_side <= 1'b0;
        p_home    <= 1'b1;
      end else if (advance) begin
        if (!late_side) begin
          if (idx_e == P_TOP) begin
            idx_e     <= '0;
            late_side <= 1'b1;
            p_clr_e   <= 1'b1;
          end else begin
            idx_e    <= idx_e + P_W'(1);
            p_step_e <= 1'b1;
          end
        end else begin
          if (idx_l == P_TOP) begin
            idx_l     <= '0;
            late_side <= 1'b0;
            idx_v     <= idx_v + V_W'(1);
            p_clr_l   <= 1'b1;
            p_step_v  <= 1'b1;
          end else begin
            idx_l    <= idx_l + P_W'(1);
            p_step_l <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mer_best_tracker.sv
// Keeps the passing mask with the largest (v+1)*(e+l+2) score.
module mer_best_tracker #(
  parameter int V_W = 3,
  parameter int P_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           offer,
  input  logic [V_W-1:0] cand_v,
  input  logic [P_W-1:0] cand_e,
  input  logic [P_W-1:0] cand_l,
  output logic           best_valid,
  output logic [V_W-1:0] best_v,
  output logic [P_W-1:0] best_e,
  output logic [P_W-1:0] best_l
);
  localparam int S_W = V_W + P_W + 3;

  logic [S_W-1:0] cand_score;
  logic [S_W-1:0] best_score;
  logic           better;

  assign cand_score = (S_W'(cand_v) + S_W'(1)) *
                      (S_W'(cand_e) + S_W'(cand_l) + S_W'(2));
  assign better     = !best_valid || (cand_score > best_score);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_valid <= 1'b0;
      best_score <= '0;
      best_v     <= '0;
      best_e     <= '0;
      best_l     <= '0;
    end else if (clear) begin
      best_valid <= 1'b0;
      best_score <= '0;
      best_v     <= '0;
      best_e     <= '0;
      best_l     <= '0;
    end else if (offer && better) begin
      best_valid <= 1'b1;
      best_score <= cand_score;
      best_v     <= cand_v;
      best_e     <= cand_e;
      best_l     <= cand_l;
    end
  end
endmodule

// File: rtl/mer_sweep_seq.sv
// Top: sweep sequencing, window control, result stream and best mask.
module mer_sweep_seq #(
  parameter int NUM_V        = 7,
  parameter int NUM_P        = 15,
  parameter int MAX_WIN_LOG2 = 16,
  parameter int PRESCALE     = 1,
  parameter int RATE_FRAC    = 8,
  localparam int V_W    = $clog2(NUM_V),
  localparam int P_W    = $clog2(NUM_P),
  localparam int WL_W   = $clog2(MAX_WIN_LOG2 + 1),
  localparam int CNT_W  = MAX_WIN_LOG2 + 1,
  localparam int PRE_W  = $clog2(PRESCALE + 1),
  localparam int RATE_W = CNT_W + PRE_W + RATE_FRAC + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] cfg_thresh,
  input  logic [WL_W-1:0]   cfg_win_log2,
  input  logic              err_pulse,
  output logic [V_W-1:0]    mask_v,
  output logic [P_W-1:0]    mask_e,
  output logic [P_W-1:0]    mask_l,
  output logic              ctl_home,
  output logic              ctl_step_v,
  output logic              ctl_step_e,
  output logic              ctl_step_l,
  output logic              ctl_clr_e,
  output logic              ctl_clr_l,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [V_W-1:0]    res_v,
  output logic [P_W-1:0]    res_e,
  output logic [P_W-1:0]    res_l,
  output logic [CNT_W-1:0]  res_count,
  output logic [RATE_W-1:0] res_rate,
  output logic              res_pass,
  output logic              busy,
  output logic              done,
  output logic              best_valid,
  output logic [V_W-1:0]    best_v,
  output logic [P_W-1:0]    best_e,
  output logic [P_W-1:0]    best_l
);
  import mer_pkg::*;

  seq_state_e        state;
  logic [RATE_W-1:0] thr_q;
  logic [WL_W-1:0]   wl_q;
  logic              start_ok;
  logic              accept;
  logic              advance;
  logic              last;
  logic              win_end;
  logic              measuring;
  logic [CNT_W-1:0]  err_cnt;

  assign start_ok  = start && (state == ST_IDLE);
  assign measuring = (state == ST_MEAS);
  assign res_valid = (state == ST_REPORT);
  assign accept    = res_valid && res_ready;
  assign advance   = accept && !last;
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      thr_q <= '0;
      wl_q  <= WL_W'(1);
      done  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            thr_q <= cfg_thresh;
            if (cfg_win_log2 == '0)
              wl_q <= WL_W'(1);
            else if (cfg_win_log2 > WL_W'(MAX_WIN_LOG2))
              wl_q <= WL_W'(MAX_WIN_LOG2);
            else
              wl_q <= cfg_win_log2;
            done  <= 1'b0;
            state <= ST_MEAS;
          end
        end
        ST_MEAS: begin
          if (win_end) state <= ST_REPORT;
        end
        ST_REPORT: begin
          if (res_ready) begin
            if (last) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state <= ST_MEAS;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  mer_mask_stepper #(
    .NUM_V(NUM_V), .NUM_P(NUM_P), .V_W(V_W), .P_W(P_W)
  ) u_stepper (
    .clk      (clk),
    .rst_n    (rst_n),
    .home     (start_ok),
    .advance  (advance),
    .idx_v    (mask_v),
    .idx_e    (mask_e),
    .idx_l    (mask_l),
    .last     (last),
    .p_home   (ctl_home),
    .p_step_v (ctl_step_v),
    .p_step_e (ctl_step_e),
    .p_step_l (ctl_step_l),
    .p_clr_e  (ctl_clr_e),
    .p_clr_l  (ctl_clr_l)
  );

  mer_window_counter #(
    .MAX_WIN_LOG2(MAX_WIN_LOG2), .WL_W(WL_W), .CNT_W(CNT_W)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_ok || advance),
    .run      (measuring),
    .err      (err_pulse),
    .win_log2 (wl_q),
    .err_cnt  (err_cnt),
    .win_end  (win_end)
  );

  mer_rate_calc #(
    .CNT_W(CNT_W), .WL_W(WL_W), .PRESCALE(PRESCALE),
    .RATE_FRAC(RATE_FRAC), .RATE_W(RATE_W)
  ) u_rate (
    .err_cnt  (err_cnt),
    .win_log2 (wl_q),
    .thresh   (thr_q),
    .rate     (res_rate),
    .pass     (res_pass)
  );

  mer_best_tracker #(
    .V_W(V_W), .P_W(P_W)
  ) u_best (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_ok),
    .offer      (accept && res_pass),
    .cand_v     (mask_v),
    .cand_e     (mask_e),
    .cand_l     (mask_l),
    .best_valid (best_valid),
    .best_v     (best_v),
    .best_e     (best_e),
    .best_l     (best_l)
  );

  assign res_v     = mask_v;
  assign res_e     = mask_e;
  assign res_l     = mask_l;
  assign res_count = err_cnt;
endmodule

// File: rtl/mer_sweep_seq_chk.sv
// Port-level properties of the sweep sequencer.
module mer_sweep_seq_chk #(
  parameter int NUM_V  = 7,
  parameter int NUM_P  = 15,
  parameter int V_W    = 3,
  parameter int P_W    = 4,
  parameter int CNT_W  = 17,
  parameter int RATE_W = 27
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              ctl_home,
  input logic              ctl_step_e,
  input logic              ctl_step_l,
  input logic              ctl_clr_e,
  input logic              ctl_clr_l,
  input logic              res_valid,
  input logic              res_ready,
  input logic [V_W-1:0]    res_v,
  input logic [P_W-1:0]    res_e,
  input logic [P_W-1:0]    res_l,
  input logic [CNT_W-1:0]  res_count,
  input logic [RATE_W-1:0] res_rate,
  input logic              res_pass,
  input logic              busy,
  input logic              done,
  input logic              best_valid,
  input logic [V_W-1:0]    best_v,
  input logic [P_W-1:0]    best_e,
  input logic [P_W-1:0]    best_l
);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_v) && $stable(res_e) &&
      $stable(res_l) && $stable(res_count) && $stable(res_rate) && $stable(res_pass)));

  p_one_side_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_e == '0 || res_l == '0));

  p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_v <= V_W'(NUM_V - 1) && res_e <= P_W'(NUM_P - 1) &&
                   res_l <= P_W'(NUM_P - 1)));

  p_zero_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_count == '0) |-> (res_rate == '0 && res_pass));

  p_pulse_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_home, ctl_step_e, ctl_step_l, ctl_clr_e, ctl_clr_l}));

  p_fail_keeps_best_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !res_pass) |=>
      ($stable(best_valid) && $stable(best_v) && $stable(best_e) && $stable(best_l)));

  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !res_valid));

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  p_busy_start_best_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && best_valid) |=> best_valid);
endmodule

bind mer_sweep_seq mer_sweep_seq_chk #(
  .NUM_V(NUM_V), .NUM_P(NUM_P), .V_W(V_W), .P_W(P_W), .CNT_W(CNT_W), .RATE_W(RATE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .ctl_home(ctl_home), .ctl_step_e(ctl_step_e), .ctl_step_l(ctl_step_l),
  .ctl_clr_e(ctl_clr_e), .ctl_clr_l(ctl_clr_l),
  .res_valid(res_valid), .res_ready(res_ready), .res_v(res_v), .res_e(res_e),
  .res_l(res_l), .res_count(res_count), .res_rate(res_rate), .res_pass(res_pass),
  .busy(busy), .done(done), .best_valid(best_valid),
  .best_v(best_v), .best_e(best_e), .best_l(best_l)
);

// File: tb/test_mer_sweep_seq.sv
`timescale 1ns/1ps
module test_mer_sweep_seq;
  localparam int NV     = 7;
  localparam int NP     = 15;
  localparam int MAXW   = 16;
  localparam int PRE    = 1;
  localparam int FRAC   = 8;
  localparam int VW     = $clog2(NV);
  localparam int PW     = $clog2(NP);
  localparam int WLW    = $clog2(MAXW + 1);
  localparam int CW     = MAXW + 1;
  localparam int RW     = CW + $clog2(PRE + 1) + FRAC + 1;
  localparam int TOTAL  = 2 * NV * NP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [RW-1:0] cfg_thresh = '0;
  logic [WLW-1:0] cfg_win_log2 = '0;
  logic          err_pulse = 1'b0;
  logic          res_ready = 1'b0;
  logic [VW-1:0] mask_v, res_v, best_v;
  logic [PW-1:0] mask_e, mask_l, res_e, res_l, best_e, best_l;
  logic          ctl_home, ctl_step_v, ctl_step_e, ctl_step_l, ctl_clr_e, ctl_clr_l;
  logic          res_valid, res_pass, busy, done, best_valid;
  logic [CW-1:0] res_count;
  logic [RW-1:0] res_rate;

  always #2 clk = ~clk;

  mer_sweep_seq i_mer_sweep_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_thresh(cfg_thresh),
    .cfg_win_log2(cfg_win_log2), .err_pulse(err_pulse),
    .mask_v(mask_v), .mask_e(mask_e), .mask_l(mask_l),
    .ctl_home(ctl_home), .ctl_step_v(ctl_step_v), .ctl_step_e(ctl_step_e),
    .ctl_step_l(ctl_step_l), .ctl_clr_e(ctl_clr_e), .ctl_clr_l(ctl_clr_l),
    .res_valid(res_valid), .res_ready(res_ready), .res_v(res_v), .res_e(res_e),
    .res_l(res_l), .res_count(res_count), .res_rate(res_rate), .res_pass(res_pass),
    .busy(busy), .done(done), .best_valid(best_valid),
    .best_v(best_v), .best_e(best_e), .best_l(best_l)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R1 watchdog cycles actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // Error source: closes faster on the late side (asymmetric eye).
  function automatic int err_class(input int v, input int e, input int l);
    int s;
    s = v + e + 2 * l;
    if (s <= 8) return 0;
    if (s == 9) return 1;
    return 2;
  endfunction

  logic tog = 1'b0;
  always @(negedge clk) begin
    int c;
    tog = ~tog;
    c = err_class(int'(mask_v), int'(mask_e), int'(mask_l));
    err_pulse = (c == 2) ? 1'b1 : ((c == 1) ? tog : 1'b0);
  end

  // Mask controller model driven only by the pulses.
  int pos_v = 0, pos_e = 0, pos_l = 0;
  int n_home = 0, n_sv = 0, n_se = 0, n_sl = 0, n_ce = 0, n_cl = 0;
  always @(negedge clk) begin
    if (ctl_home)   begin n_home++; pos_v = 0; pos_e = 0; pos_l = 0; end
    if (ctl_step_v) begin n_sv++; pos_v++; end
    if (ctl_step_e) begin n_se++; pos_e++; end
    if (ctl_step_l) begin n_sl++; pos_l++; end
    if (ctl_clr_e)  begin n_ce++; pos_e = 0; end
    if (ctl_clr_l)  begin n_cl++; pos_l = 0; end
  end

  function automatic void idx_coords(input int idx, output int v, output int e, output int l);
    int r;
    v = idx / (2 * NP);
    r = idx % (2 * NP);
    e = (r < NP) ? r : 0;
    l = (r < NP) ? 0 : r - NP;
  endfunction

  task automatic run_sweep(input longint thr, input int wl_in, input int stall,
                           input bit poke);
    int w, win, idx, waited;
    int h0, sv0, se0, sl0, ce0, cl0;
    int bv, be, bl, bscore;
    bit bfound;
    logic [VW-1:0] sv;
    logic [PW-1:0] se, sl;
    logic [CW-1:0] sc;
    logic [RW-1:0] sr;
    logic sp;
    bit moved;
    w   = (wl_in == 0) ? 1 : ((wl_in > MAXW) ? MAXW : wl_in);
    win = 1 << w;
    h0 = n_home; sv0 = n_sv; se0 = n_se; sl0 = n_sl; ce0 = n_ce; cl0 = n_cl;
    bfound = 0; bv = 0; be = 0; bl = 0; bscore = 0;

    @(negedge clk);
    cfg_thresh   = RW'(thr);
    cfg_win_log2 = WLW'(wl_in);
    start        = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7", "busy after start", busy, 1);
    check(done == 1'b0, "R7", "done cleared at start", done, 0);
    check(best_valid == 1'b0, "R7", "best cleared at start", best_valid, 0);

    idx = 0; waited = 0; moved = 0;
    sv = '0; se = '0; sl = '0; sc = '0; sr = '0; sp = 1'b0;
    while (idx < TOTAL) begin
      @(negedge clk);
      if (start) begin
        start = 1'b0;
        check(busy == 1'b1, "R8", "start while busy ignored", busy, 1);
      end
      if (res_valid) begin
        if (waited == 0) begin
          int v, e, l, c, ec;
          longint er;
          bit ep;
          idx_coords(idx, v, e, l);
          c  = err_class(v, e, l);
          ec = (c == 0) ? 0 : ((c == 1) ? win / 2 : win);
          er = (longint'(ec) * PRE * (longint'(1) << (FRAC + 1))) >> w;
          ep = (er <= thr);
          check(int'(res_v) == v && int'(res_e) == e && int'(res_l) == l,
                "R1", "record coords (v*1000+e*100+l)",
                int'(res_v) * 1000 + int'(res_e) * 100 + int'(res_l), v * 1000 + e * 100 + l);
          check(pos_v == v && pos_e == e && pos_l == l, "R5",
                "controller position from pulses (v*1000+e*100+l)",
                pos_v * 1000 + pos_e * 100 + pos_l, v * 1000 + e * 100 + l);
          check(int'(res_count) == ec, "R2", "window error count", res_count, ec);
          check(longint'(res_rate) == er && res_pass == ep, "R3", "rate*2+pass",
                longint'(res_rate) * 2 + res_pass, er * 2 + ep);
          if (ep) begin
            int s;
            s = (v + 1) * (e + l + 2);
            if (!bfound || s > bscore) begin
              bfound = 1; bscore = s; bv = v; be = e; bl = l;
            end
          end
          sv = res_v; se = res_e; sl = res_l; sc = res_count; sr = res_rate; sp = res_pass;
          moved = 0;
        end else begin
          if (res_v != sv || res_e != se || res_l != sl || res_count != sc ||
              res_rate != sr || res_pass != sp) moved = 1;
        end
        if (waited < stall) begin
          res_ready = 1'b0;
          waited++;
        end else begin
          if (stall > 0)
            check(!moved, "R4", "record held while stalled", moved, 0);
          res_ready = 1'b1;
          waited = 0;
          idx++;
          if (poke && idx == 40) begin
            cfg_thresh   = '0;
            cfg_win_log2 = WLW'(5);
            start        = 1'b1;
          end
        end
      end else begin
        res_ready = 1'b0;
        if (waited != 0) begin
          check(1'b0, "R4", "valid dropped while stalled", 0, 1);
          waited = 0;
        end
      end
    end
    @(negedge clk);
    res_ready = 1'b0;
    check(done == 1'b1 && busy == 1'b0, "R7", "done*2+busy after last record",
          done * 2 + busy, 2);
    check(res_valid == 1'b0, "R1", "no record beyond last", res_valid, 0);
    check(n_home - h0 == 1, "R5", "home pulses", n_home - h0, 1);
    check(n_se - se0 == NV * (NP - 1), "R5", "early step pulses", n_se - se0, NV * (NP - 1));
    check(n_sl - sl0 == NV * (NP - 1), "R5", "late step pulses", n_sl - sl0, NV * (NP - 1));
    check(n_ce - ce0 == NV, "R5", "early clear pulses", n_ce - ce0, NV);
    check(n_cl - cl0 == NV - 1, "R5", "late clear pulses", n_cl - cl0, NV - 1);
    check(n_sv - sv0 == NV - 1, "R5", "level step pulses", n_sv - sv0, NV - 1);
    check(best_valid == bfound, "R6", "best valid", best_valid, bfound);
    if (bfound)
      check(int'(best_v) == bv && int'(best_e) == be && int'(best_l) == bl, "R6",
            "best coords (v*1000+e*100+l)",
            int'(best_v) * 1000 + int'(best_e) * 100 + int'(best_l), bv * 1000 + be * 100 + bl);
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R7", "done holds while idle", done, 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R9", "busy/done after reset", busy + done, 0);
    check(res_valid == 1'b0, "R9", "valid after reset", res_valid, 0);
    check(best_valid == 1'b0, "R9", "best after reset", best_valid, 0);
    check({ctl_home, ctl_step_v, ctl_step_e, ctl_step_l, ctl_clr_e, ctl_clr_l} == 6'b0,
          "R9", "control pulses after reset",
          {ctl_home, ctl_step_v, ctl_step_e, ctl_step_l, ctl_clr_e, ctl_clr_l}, 0);
  endtask

  // R1 R2 R3 R5 R6: only error-free masks pass
  task automatic t_strict;
    run_sweep(0, 3, 0, 1'b0);
  endtask

  // R4 R8: stalled stream, threshold at 1.0, start and config poked mid-sweep
  task automatic t_backpressure;
    run_sweep(256, 3, 2, 1'b1);
  endtask

  // R2 R3: longer window, threshold between half and full error density
  task automatic t_long_window;
    run_sweep(300, 4, 1, 1'b0);
  endtask

  // R2: exponent 0 is read as 1 (two-cycle window)
  task automatic t_window_clamp;
    run_sweep(0, 0, 0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_strict();
    t_backpressure();
    t_long_window();
    t_window_clamp();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule